// File: doc/BRIEF.md
# Serial Configuration Master with Error Detection

This block feeds a stored configuration bitstream to a programmable target device, one bit at a time, over a serial clock and a serial data line that it generates itself. The bitstream is read through a simple byte-wide read port. Bits go out least significant first within each byte. Data changes while the serial clock is low, so it is stable at every rising edge.

The block watches a done line from the target, which is high when the target has finished. It also shares an open-drain enable/status line with the target. The block pulls that line low to report an error. Two faults count as errors:
- The target reports done while bits are still being sent.
- The target fails to report done within a fixed window of serial clocks after the last bit.

An external low on the shared line, for example from the target reporting a data error, aborts the stream. The block holds off while the line is low and starts again from bit 0 once the line is released. With the auto-restart input set, the block drops its error low after a minimum hold time and streams again. With the input clear, it stays in the error state until reset.

When reset is released, the block waits for the shared line to read high. It then samples the done line. If done reads high, the block takes the slave role: it drives neither the clock nor the data, and it never streams.

Top module: `cfg_serial_master`

## Requirements
- R1: If the done input reads high on the first cycle after reset in which the enable line reads high, the block enters slave mode. In slave mode `slave_mode`=1, `sclk_oe`=0, `sdata_oe`=0 and `oe_pull`=0 from then until reset, whatever the other inputs do.
- R2: In master mode the block sends NBITS bits, one per rising edge of `sclk_out`. Bit n is bit (n mod 8) of the byte at address n/8, so each byte goes out least significant bit first. `sdata_out` changes only in cycles where `sclk_out` is not rising.
- R3: If done is high during streaming, before the cycle that completes the last bit, `oe_pull` rises at the next clock. No further rising edge of `sclk_out` follows.
- R4: If done stays low after the last bit's rising edge, `oe_pull` rises after exactly 16 further rising edges of `sclk_out`.
- R5: If done rises within the 16-edge window, the block settles with `sclk_out`=0, `sdata_oe`=0 and `oe_pull`=0. It stays there until reset, and later changes of done have no effect.
- R6: With `auto_restart`=0, `oe_pull` stays high after an error until reset, and no serial clock edges follow.
- R7: With `auto_restart`=1, `oe_pull` is high for exactly 4 clock cycles. The stream then restarts from bit 0.
- R8: An external low on the enable line during streaming stops the clock (`sclk_out`=0) and tri-states data (`sdata_oe`=0) without asserting `oe_pull`. When the line is released, the stream restarts from bit 0.
- R9: While the enable line is held low after reset, the block neither streams nor picks a role. The done level is sampled only when the line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Power-on reset, active low |
| auto_restart | input | 1 | Restart streaming automatically after an error |
| tgt_done | input | 1 | Done / chip-select level from the target, high when finished |
| oe_in | input | 1 | Sampled level of the shared enable/status line |
| oe_pull | output | 1 | 1 pulls the shared line low (error) |
| rd_addr | output | $clog2(NBITS)-3 | Byte address into the bitstream store |
| rd_data | input | 8 | Byte read from the store, same cycle |
| sclk_out | output | 1 | Serial clock to the target |
| sclk_oe | output | 1 | Drive enable for the serial clock pin |
| sdata_out | output | 1 | Serial data to the target |
| sdata_oe | output | 1 | Drive enable for the serial data pin |
| slave_mode | output | 1 | High once the slave role is chosen |

## Verification
A wrong bit counter shows up at the very next rising edge of the serial clock, as a data bit that does not match the store. A counter that is off by one at the end changes the number of edges seen before done or the error. A wrong window count moves the error by whole serial clocks, so counting the edges between the last bit and `oe_pull` exposes it within 16 edges. A wrong state choice at reset shows within a few cycles, as clock activity where none is allowed or none where it is expected. An error hold that is too short or too long changes the measured pulse width.

// File: rtl/cfg_serial_master.sv
module cfg_serial_master #(
  parameter int NBITS = 64,
  parameter int WIN   = 16,
  parameter int HOLD  = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       auto_restart,
  input  logic                       tgt_done,
  input  logic                       oe_in,
  output logic                       oe_pull,
  output logic [$clog2(NBITS)-4:0]   rd_addr,
  input  logic [7:0]                 rd_data,
  output logic                       sclk_out,
  output logic                       sclk_oe,
  output logic                       sdata_out,
  output logic                       sdata_oe,
  output logic                       slave_mode
);
  localparam int CW = $clog2(NBITS);
  localparam int WW = $clog2(WIN + 1);
  localparam int HW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] LAST = CW'(NBITS - 1);

  typedef enum logic [2:0] {S_INIT, S_STREAM, S_WAIT, S_DONE, S_ERR, S_HOLD, S_SLAVE} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [WW-1:0] win;
  logic [HW-1:0] hold;
  logic          sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_INIT;
      cnt    <= '0;
      win    <= '0;
      hold   <= '0;
      sclk_q <= 1'b0;
    end else begin
      case (st)
        S_INIT: begin
          cnt    <= '0;
          sclk_q <= 1'b0;
          if (oe_in) st <= tgt_done ? S_SLAVE : S_STREAM;
        end
        S_STREAM: begin
          if (!oe_in) begin
            st     <= S_HOLD;
            sclk_q <= 1'b0;
          end else if (tgt_done) begin
            st     <= S_ERR;
            hold   <= '0;
            sclk_q <= 1'b0;
          end else begin
            sclk_q <= ~sclk_q;
            if (sclk_q) begin
              if (cnt == LAST) begin
                st  <= S_WAIT;
                win <= '0;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
        end
        S_WAIT: begin
          if (!oe_in) begin
            st     <= S_HOLD;
            sclk_q <= 1'b0;
          end else if (tgt_done) begin
            st     <= S_DONE;
            sclk_q <= 1'b0;
          end else begin
            sclk_q <= ~sclk_q;
            if (sclk_q) begin
              if (win == WW'(WIN - 1)) begin
                st     <= S_ERR;
                hold   <= '0;
                sclk_q <= 1'b0;
              end else begin
                win <= win + 1'b1;
              end
            end
          end
        end
        S_ERR: begin
          if (hold < HW'(HOLD - 1)) hold <= hold + 1'b1;
          else if (auto_restart) begin
            st  <= S_STREAM;
            cnt <= '0;
          end
        end
        S_HOLD: begin
          if (oe_in) begin
            st  <= S_STREAM;
            cnt <= '0;
          end
        end
        default: ;
      endcase
    end
  end

  assign oe_pull    = (st == S_ERR);
  assign slave_mode = (st == S_SLAVE);
  assign sclk_out   = sclk_q;
  assign sclk_oe    = (st != S_INIT) && (st != S_SLAVE);
  assign sdata_oe   = (st == S_STREAM) || (st == S_WAIT);
  assign rd_addr    = cnt[CW-1:3];
  assign sdata_out  = sdata_oe ? rd_data[cnt[2:0]] : 1'b0;

  assert_slave_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    slave_mode |-> (!sclk_oe && !sdata_oe && !oe_pull));

  assert_data_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_out) |-> $stable(sdata_out));

  assert_early_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STREAM && oe_in && tgt_done) |=> oe_pull);

  assert_timeout_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && oe_in && !tgt_done && sclk_q && win == WW'(WIN - 1)) |=> oe_pull);

  assert_done_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DONE) |=> (st == S_DONE && !sclk_out));

  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_pull && !auto_restart) |=> oe_pull);

  assert_hold_min_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe_pull) |-> $past(oe_pull, 4));
endmodule

// File: tb/sim_cfg_serial_master.sv
`timescale 1ns/1ps
module sim_cfg_serial_master;
  localparam int NB  = 32;
  localparam int NBY = NB / 8;

  logic clk = 0, rst_n = 0, auto_restart = 0, tgt_done = 0, ext_low = 0;
  logic oe_pull, sclk_out, sclk_oe, sdata_out, sdata_oe, slave_mode;
  logic [$clog2(NB)-4:0] rd_addr;
  logic [7:0] rd_data;
  logic [7:0] mem [NBY];
  logic oe_line;

  int errors = 0, total = 0;
  int rise_idx = 0, mism = 0;
  logic prev_sclk = 0, prev_doe = 0;

  always #2.5 clk = ~clk;
  assign oe_line = !(oe_pull || ext_low);
  assign rd_data = mem[rd_addr];

  cfg_serial_master #(.NBITS(NB), .WIN(16), .HOLD(4)) u0 (
    .clk(clk), .rst_n(rst_n), .auto_restart(auto_restart), .tgt_done(tgt_done),
    .oe_in(oe_line), .oe_pull(oe_pull), .rd_addr(rd_addr), .rd_data(rd_data),
    .sclk_out(sclk_out), .sclk_oe(sclk_oe), .sdata_out(sdata_out),
    .sdata_oe(sdata_oe), .slave_mode(slave_mode));

  function automatic logic exp_bit(int idx);
    return mem[idx / 8][idx % 8];
  endfunction

  always @(posedge clk) begin
    #1;
    if (sdata_oe && !prev_doe) rise_idx = 0;
    if (sclk_out && !prev_sclk) begin
      if (sdata_oe && rise_idx < NB && sdata_out !== exp_bit(rise_idx)) mism++;
      rise_idx++;
    end
    prev_sclk = sclk_out;
    prev_doe  = sdata_oe;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic fill_mem();
    for (int i = 0; i < NBY; i++) mem[i] = 8'($urandom);
  endtask

  task automatic do_reset(input logic d, input logic e);
    rst_n = 0; tgt_done = d; ext_low = e;
    repeat (3) @(negedge clk);
    rise_idx = 0; mism = 0;
    rst_n = 1;
  endtask

  task automatic wait_idx(input int n);
    while (rise_idx < n) @(negedge clk);
  endtask

  task automatic run_early(input int k);
    wait_idx(k);
    tgt_done = 1;
    @(negedge clk);
    chk(oe_pull == 1, "R3 early done flags error", oe_pull, 1);
    repeat (6) @(negedge clk);
    chk(rise_idx == k, "R3 no clock after early done", rise_idx, k);
    chk(mism == 0, "R2 bits before early done", mism, 0);
  endtask

  task automatic run_success(input int j);
    wait_idx(NB + j);
    tgt_done = 1;
    repeat (8) @(negedge clk);
    chk(!oe_pull && !sdata_oe && !sclk_out, "R5 idle after success",
        {oe_pull, sdata_oe, sclk_out}, 0);
    chk(rise_idx == NB + j, "R5 clock stopped", rise_idx, NB + j);
    chk(mism == 0, "R2 full stream bits", mism, 0);
    tgt_done = 0;
    repeat (10) @(negedge clk);
    chk(!oe_pull && !sdata_oe && rise_idx == NB + j, "R5 done drop ignored",
        rise_idx, NB + j);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    fill_mem();

    // reset state
    rst_n = 0;
    @(negedge clk);
    chk(!oe_pull && !sdata_oe && !sclk_oe && !slave_mode, "R1 reset outputs",
        {oe_pull, sdata_oe, sclk_oe, slave_mode}, 0);

    // R1 slave selection
    do_reset(1, 0);
    repeat (5) @(negedge clk);
    tgt_done = 0; auto_restart = 1;
    repeat (35) @(negedge clk);
    chk(slave_mode && !sclk_oe && !sdata_oe && !oe_pull, "R1 slave quiet",
        {slave_mode, sclk_oe, sdata_oe, oe_pull}, 8);
    chk(rise_idx == 0, "R1 slave no clock", rise_idx, 0);

    // R9 role sampled at line release
    do_reset(0, 1);
    repeat (5) @(negedge clk);
    tgt_done = 1;
    repeat (10) @(negedge clk);
    tgt_done = 0;
    repeat (5) @(negedge clk);
    chk(!slave_mode && !sdata_oe && rise_idx == 0, "R9 idle while line low",
        rise_idx, 0);
    ext_low = 0;
    repeat (12) @(negedge clk);
    chk(!slave_mode && rise_idx > 0, "R9 master after release", rise_idx, 1);
    run_success(3);

    // R4 timeout and R6 sticky error
    fill_mem(); auto_restart = 0;
    do_reset(0, 0);
    while (!oe_pull) @(negedge clk);
    chk(rise_idx == NB + 16, "R4 timeout edge count", rise_idx, NB + 16);
    chk(mism == 0, "R2 bits before timeout", mism, 0);
    repeat (30) @(negedge clk);
    chk(oe_pull == 1, "R6 error held", oe_pull, 1);
    chk(rise_idx == NB + 16, "R6 no clock in error", rise_idx, NB + 16);

    // R7 auto restart
    fill_mem(); auto_restart = 1;
    do_reset(0, 0);
    while (!oe_pull) @(negedge clk);
    begin
      int n = 0;
      while (oe_pull) begin n++; @(negedge clk); end
      chk(n == 4, "R7 error pulse width", n, 4);
    end
    mism = 0;
    wait_idx(NB);
    chk(mism == 0 && rise_idx == NB, "R7 restart from bit 0", mism, 0);
    run_success(1);

    // R8 external low during stream
    fill_mem(); auto_restart = 0;
    do_reset(0, 0);
    wait_idx(NB / 2 + 1);
    ext_low = 1;
    @(negedge clk);
    @(negedge clk);
    chk(!sdata_oe && !sclk_out && !oe_pull, "R8 hold off on external low",
        {sdata_oe, sclk_out, oe_pull}, 0);
    repeat (5) @(negedge clk);
    ext_low = 0; mism = 0;
    repeat (4) @(negedge clk);
    chk(rise_idx <= 2, "R8 restart count", rise_idx, 1);
    run_success(2);

    // R5 window boundary: done on the 16th extra edge
    fill_mem();
    do_reset(0, 0);
    run_success(16);

    // random rounds
    for (int r = 0; r < 8; r++) begin
      fill_mem();
      auto_restart = 0;
      do_reset(0, 0);
      if (r % 2 == 0) run_early(1 + int'($urandom % (NB - 1)));
      else run_success(1 + int'($urandom % 16));
    end

    $display("Result: errors=%0d of %0d checks", errors, total);
    $finish;
  end
endmodule